// File: doc/BRIEF.md
# Sticky Alarm Interrupt Controller

This block turns four alarm conditions into sticky status flags. The conditions are PLL loss-of-lock, holdover, and loss-of-signal on clock inputs 0 and 1. Each flag can be enabled as an interrupt source. When any enabled flag is set, the block raises a summary status bit and drives an active-low interrupt pin low. Software reads the flags through a small register port. It clears a flag by writing a one to that flag's bit. The clear takes effect only once the alarm behind the flag has gone away.

The loss-of-lock alarm goes through a release qualifier before it reaches its flag, and the qualified alarm is also brought out on a pin. The qualifier has two release modes. In the lock mode the alarm follows the raw unlock indication. In the sync mode the alarm stays raised after lock returns, for as long as an internal synchronization-busy input is high. This keeps the alarm up until the outputs are stable again. The block does not detect alarms itself. It consumes them as level inputs.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: The flag register (address 0) holds four flags: bit 0 loss-of-lock, bit 1 holdover, bit 2 loss-of-signal input 0, bit 3 loss-of-signal input 1. A holdover or loss-of-signal flag reads as set starting with the clock edge at which its alarm input is sampled high.
- R2: While a flag's alarm is active, writing a 1 to that flag's bit is ignored and the flag stays set.
- R3: Once its alarm is inactive, a set flag stays set until a write of 1 to its bit at address 0. That write clears the flag at the edge where the write is sampled.
- R4: Writing 0 to a flag bit leaves that flag unchanged.
- R5: When the alarm is active in the same cycle as a clearing write to its flag, the flag stays set.
- R6: Synchronous reset clears all four flags, all interrupt enables (address 1, same bit positions as the flags) and the release mode (address 2, bit 0), and drives the interrupt pin high.
- R7: The summary status output and address 3 bit 0 go high, and the interrupt pin goes low, one clock after any flag is set with its enable bit at 1. Clearing an enable bit removes that flag's effect on the pin one clock after the write, and the flag itself stays set.
- R8: Release mode 0 (lock): the qualified loss-of-lock alarm pin goes high one clock after the raw unlock input is sampled high, and low one clock after it is sampled low. Release mode 1 (sync): after the raw input drops, the alarm stays high while sync-busy is sampled high, and it drops at the first edge where sync-busy is sampled low. The loss-of-lock flag follows the qualified alarm under R1–R3 timing, one cycle later.
- R9: Reads are combinational. Address 2 returns the release mode in bit 0, address 3 returns the summary status in bit 0, and the other bits at those addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lol_raw_i | input | 1 | Raw PLL unlocked indication |
| hold_i | input | 1 | Holdover alarm |
| los_i | input | 2 | Loss-of-signal alarm per clock input |
| sync_busy_i | input | 1 | High while disruptive synchronization is in progress |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 4 | Register write data |
| reg_rdata_o | output | 4 | Register read data |
| lol_alarm_o | output | 1 | Qualified loss-of-lock alarm |
| irq_status_o | output | 1 | Summary interrupt status, active high |
| irq_n_o | output | 1 | Interrupt pin, active low |

## Verification
A corrupted flag shows up at the interrupt pin one clock after it goes wrong, provided its enable is set. It also shows on a read of address 0 in the same cycle. A lost set therefore appears as a pin that fails to fall on the second edge after the alarm. A clear that happens too early appears as a flag reading zero while its alarm is still high. The loss-of-lock qualifier is observed directly on its own pin, so a release one cycle too early in sync mode is visible while sync-busy is still high. A stuck enable or mode register shows up in the read-back and at the pin on the next edge.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;

    localparam int NUM_FLAGS = 4;
    localparam int ADDR_W    = 2;
    localparam int DATA_W    = NUM_FLAGS;

    typedef logic [NUM_FLAGS-1:0] flag_vec_t;
    typedef logic [DATA_W-1:0]    reg_data_t;

    typedef enum logic [1:0] {
        FLG_LOL  = 2'd0,
        FLG_HOLD = 2'd1,
        FLG_LOS0 = 2'd2,
        FLG_LOS1 = 2'd3
    } flag_idx_e;

    typedef enum logic [ADDR_W-1:0] {
        REG_FLAGS   = 2'd0,
        REG_ENABLE  = 2'd1,
        REG_CONFIG  = 2'd2,
        REG_SUMMARY = 2'd3
    } reg_addr_e;

    typedef enum logic {
        LOL_REL_LOCK = 1'b0,
        LOL_REL_SYNC = 1'b1
    } lol_mode_e;

    typedef struct packed {
        logic      wr;
        reg_addr_e addr;
        reg_data_t wdata;
    } reg_req_t;

    function automatic reg_data_t pack_bit(logic b);
        reg_data_t r;
        r    = '0;
        r[0] = b;
        return r;
    endfunction

    function automatic flag_vec_t build_alarms(logic lol, logic hold, logic [1:0] los);
        flag_vec_t v;
        v                       = '0;
        v[int'(FLG_LOL)]        = lol;
        v[int'(FLG_HOLD)]       = hold;
        v[int'(FLG_LOS0)]       = los[0];
        v[int'(FLG_LOS1)]       = los[1];
        return v;
    endfunction

endpackage

// File: rtl/lol_qualifier.sv
module lol_qualifier
    import alarm_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      lol_raw_i,
    input  logic      sync_busy_i,
    input  lol_mode_e mode_i,
    output logic      lol_alarm_o
);

    logic alarm_q;
    logic extend;

    assign extend = (mode_i == LOL_REL_SYNC) && sync_busy_i && alarm_q;

    always_ff @(posedge clk) begin
        if (rst) alarm_q <= 1'b0;
        else     alarm_q <= lol_raw_i || extend;
    end

    assign lol_alarm_o = alarm_q;

    a_r8_raw_raises: assert property (@(posedge clk) disable iff (rst)
        lol_raw_i |=> lol_alarm_o);

    a_r8_lock_mode_release: assert property (@(posedge clk) disable iff (rst)
        (mode_i == LOL_REL_LOCK && !lol_raw_i) |=> !lol_alarm_o);

    a_r8_sync_mode_hold: assert property (@(posedge clk) disable iff (rst)
        (mode_i == LOL_REL_SYNC && sync_busy_i && lol_alarm_o) |=> lol_alarm_o);

    a_r8_idle_release: assert property (@(posedge clk) disable iff (rst)
        (!lol_raw_i && !sync_busy_i) |=> !lol_alarm_o);

endmodule

// File: rtl/sticky_flag_bank.sv
module sticky_flag_bank
    import alarm_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flag_vec_t alarm_i,
    input  flag_vec_t clr_i,
    output flag_vec_t flags_o
);

    flag_vec_t flag_q;

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        logic release_ok;
        assign release_ok = clr_i[g] && !alarm_i[g];

        always_ff @(posedge clk) begin
            if (rst)             flag_q[g] <= 1'b0;
            else if (alarm_i[g]) flag_q[g] <= 1'b1;
            else if (release_ok) flag_q[g] <= 1'b0;
        end

        a_r2_alarm_sets: assert property (@(posedge clk) disable iff (rst)
            alarm_i[g] |=> flags_o[g]);

        a_r3_clear_when_quiet: assert property (@(posedge clk) disable iff (rst)
            (clr_i[g] && !alarm_i[g]) |=> !flags_o[g]);

        a_r4_kept_without_clear: assert property (@(posedge clk) disable iff (rst)
            (flags_o[g] && !clr_i[g]) |=> flags_o[g]);

        a_r5_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
            (clr_i[g] && alarm_i[g]) |=> flags_o[g]);
    end

    assign flags_o = flag_q;

endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
    import alarm_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flag_vec_t flags_i,
    input  flag_vec_t enable_i,
    output logic      irq_active_o
);

    flag_vec_t pending;
    logic      irq_q;

    assign pending = flags_i & enable_i;

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |pending;
    end

    assign irq_active_o = irq_q;

    a_r7_raise: assert property (@(posedge clk) disable iff (rst)
        (|(flags_i & enable_i)) |=> irq_active_o);

    a_r7_masked_drop: assert property (@(posedge clk) disable iff (rst)
        ((flags_i & enable_i) == '0) |=> !irq_active_o);

endmodule

// File: rtl/alarm_reg_block.sv
module alarm_reg_block
    import alarm_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  reg_req_t  req_i,
    input  flag_vec_t flags_i,
    input  logic      irq_active_i,
    output flag_vec_t clr_o,
    output flag_vec_t enable_o,
    output lol_mode_e mode_o,
    output reg_data_t rdata_o
);

    flag_vec_t en_q;
    lol_mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            mode_q <= LOL_REL_LOCK;
        end else if (req_i.wr) begin
            if (req_i.addr == REG_ENABLE) en_q   <= req_i.wdata;
            if (req_i.addr == REG_CONFIG) mode_q <= lol_mode_e'(req_i.wdata[0]);
        end
    end

    always_comb begin
        clr_o = '0;
        if (req_i.wr && req_i.addr == REG_FLAGS) clr_o = req_i.wdata;
    end

    always_comb begin
        unique case (req_i.addr)
            REG_FLAGS:   rdata_o = flags_i;
            REG_ENABLE:  rdata_o = en_q;
            REG_CONFIG:  rdata_o = pack_bit(mode_q == LOL_REL_SYNC);
            REG_SUMMARY: rdata_o = pack_bit(irq_active_i);
            default:     rdata_o = '0;
        endcase
    end

    assign enable_o = en_q;
    assign mode_o   = mode_q;

    a_r6_reset_defaults: assert property (@(posedge clk)
        rst |=> (enable_o == '0 && mode_o == LOL_REL_LOCK));

    a_r4_zero_write_no_clear: assert property (@(posedge clk) disable iff (rst)
        (req_i.wr && req_i.addr == REG_FLAGS) |-> (clr_o == req_i.wdata));

    a_r7_enable_hold: assert property (@(posedge clk) disable iff (rst)
        !(req_i.wr && req_i.addr == REG_ENABLE) |=> $stable(enable_o));

endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
    import alarm_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 lol_raw_i,
    input  logic                 hold_i,
    input  logic [1:0]           los_i,
    input  logic                 sync_busy_i,
    input  logic                 reg_wr_i,
    input  logic [ADDR_W-1:0]    reg_addr_i,
    input  logic [DATA_W-1:0]    reg_wdata_i,
    output logic [DATA_W-1:0]    reg_rdata_o,
    output logic                 lol_alarm_o,
    output logic                 irq_status_o,
    output logic                 irq_n_o
);

    reg_req_t  req;
    lol_mode_e mode;
    logic      lol_q;
    flag_vec_t alarms;
    flag_vec_t clr;
    flag_vec_t flags;
    flag_vec_t enables;
    logic      irq_active;

    assign req.wr    = reg_wr_i;
    assign req.addr  = reg_addr_e'(reg_addr_i);
    assign req.wdata = reg_wdata_i;

    lol_qualifier u_lol (
        .clk         (clk),
        .rst         (rst),
        .lol_raw_i   (lol_raw_i),
        .sync_busy_i (sync_busy_i),
        .mode_i      (mode),
        .lol_alarm_o (lol_q)
    );

    assign alarms = build_alarms(lol_q, hold_i, los_i);

    sticky_flag_bank u_flags (
        .clk     (clk),
        .rst     (rst),
        .alarm_i (alarms),
        .clr_i   (clr),
        .flags_o (flags)
    );

    irq_combiner u_irq (
        .clk          (clk),
        .rst          (rst),
        .flags_i      (flags),
        .enable_i     (enables),
        .irq_active_o (irq_active)
    );

    alarm_reg_block u_regs (
        .clk          (clk),
        .rst          (rst),
        .req_i        (req),
        .flags_i      (flags),
        .irq_active_i (irq_active),
        .clr_o        (clr),
        .enable_o     (enables),
        .mode_o       (mode),
        .rdata_o      (reg_rdata_o)
    );

    assign lol_alarm_o  = lol_q;
    assign irq_status_o = irq_active;
    assign irq_n_o      = !irq_active;

    a_r7_pin_matches_status: assert property (@(posedge clk) disable iff (rst)
        irq_n_o != irq_status_o);

endmodule

// File: tb/alarm_irq_ctrl_tb.sv
`timescale 1ns/1ps
module alarm_irq_ctrl_tb;

    localparam int SEL_RDATA = 0;
    localparam int SEL_IRQN  = 1;
    localparam int SEL_STAT  = 2;
    localparam int SEL_LOL   = 3;

    typedef struct {
        string      req;
        int         sel;
        logic [3:0] exp;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       lol_raw = 1'b0;
    logic       hold = 1'b0;
    logic [1:0] los = 2'b00;
    logic       sync_busy = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [3:0] reg_wdata = 4'd0;
    logic [3:0] reg_rdata;
    logic       lol_alarm;
    logic       irq_status;
    logic       irq_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    item_t sb_q[$];

    always #4 clk = ~clk;

    alarm_irq_ctrl u_dut (
        .clk          (clk),
        .rst          (rst),
        .lol_raw_i    (lol_raw),
        .hold_i       (hold),
        .los_i        (los),
        .sync_busy_i  (sync_busy),
        .reg_wr_i     (reg_wr),
        .reg_addr_i   (reg_addr),
        .reg_wdata_i  (reg_wdata),
        .reg_rdata_o  (reg_rdata),
        .lol_alarm_o  (lol_alarm),
        .irq_status_o (irq_status),
        .irq_n_o      (irq_n)
    );

    function automatic logic [3:0] observe(int sel);
        case (sel)
            SEL_RDATA: return reg_rdata;
            SEL_IRQN:  return {3'b000, irq_n};
            SEL_STAT:  return {3'b000, irq_status};
            default:   return {3'b000, lol_alarm};
        endcase
    endfunction

    // monitor: pops expected items and compares at the falling edge
    always @(negedge clk) begin
        item_t it;
        logic [3:0] act;
        while (sb_q.size() > 0) begin
            it  = sb_q.pop_front();
            act = observe(it.sel);
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(int sel, logic [3:0] exp, string req);
        item_t it;
        it.req = req; it.sel = sel; it.exp = exp;
        sb_q.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic chk_reg(logic [1:0] addr, logic [3:0] exp, string req);
        reg_addr = addr;
        chk(SEL_RDATA, exp, req);
    endtask

    task automatic wr(logic [1:0] addr, logic [3:0] data);
        reg_wr = 1'b1; reg_addr = addr; reg_wdata = data;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        // R6 reset state
        chk_reg(2'd0, 4'h0, "R6");
        chk_reg(2'd1, 4'h0, "R6");
        chk(SEL_IRQN, 4'h1, "R6");

        // R1 / R7: holdover flag and interrupt timing
        wr(2'd1, 4'hF);
        hold = 1'b1;
        chk(SEL_IRQN, 4'h1, "R7");
        chk_reg(2'd0, 4'h2, "R1");
        chk(SEL_IRQN, 4'h0, "R7");
        chk(SEL_STAT, 4'h1, "R7");
        chk_reg(2'd3, 4'h1, "R9");

        // R2: clearing write ignored while alarm active
        wr(2'd0, 4'h2);
        chk_reg(2'd0, 4'h2, "R2");
        hold = 1'b0;
        chk_reg(2'd0, 4'h2, "R3");
        // R4: zero write has no effect
        wr(2'd0, 4'h0);
        chk_reg(2'd0, 4'h2, "R4");
        // R3: clear after alarm gone
        wr(2'd0, 4'h2);
        chk_reg(2'd0, 4'h0, "R3");
        chk(SEL_IRQN, 4'h1, "R3");

        // R5: alarm and clear in the same cycle
        los[0] = 1'b1;
        tick(); tick();
        los[0] = 1'b0;
        tick();
        los[0] = 1'b1;
        wr(2'd0, 4'h4);
        los[0] = 1'b0;
        chk_reg(2'd0, 4'h4, "R5");
        wr(2'd0, 4'h4);
        chk_reg(2'd0, 4'h0, "R5");

        // R7: disabling an enable drops the pin, flag stays
        los[1] = 1'b1;
        tick();
        los[1] = 1'b0;
        tick(); tick(); tick();
        chk(SEL_IRQN, 4'h0, "R7");
        wr(2'd1, 4'h7);
        chk(SEL_IRQN, 4'h0, "R7");
        chk(SEL_IRQN, 4'h1, "R7");
        chk_reg(2'd0, 4'h8, "R7");
        chk_reg(2'd1, 4'h7, "R7");
        chk_reg(2'd3, 4'h0, "R9");
        wr(2'd0, 4'h8);
        wr(2'd1, 4'hF);

        // R8 lock mode
        lol_raw = 1'b1;
        chk(SEL_LOL, 4'h0, "R8");
        chk(SEL_LOL, 4'h1, "R8");
        lol_raw = 1'b0;
        chk(SEL_LOL, 4'h0, "R8");
        chk_reg(2'd0, 4'h1, "R1");
        chk(SEL_IRQN, 4'h0, "R7");
        wr(2'd0, 4'h1);
        chk_reg(2'd0, 4'h0, "R3");

        // R8 sync mode
        wr(2'd2, 4'h1);
        sync_busy = 1'b1;
        lol_raw = 1'b1;
        chk(SEL_LOL, 4'h0, "R8");
        chk(SEL_LOL, 4'h1, "R8");
        lol_raw = 1'b0;
        chk(SEL_LOL, 4'h1, "R8");
        chk(SEL_LOL, 4'h1, "R8");
        wr(2'd0, 4'h1);
        chk_reg(2'd0, 4'h1, "R8");
        chk_reg(2'd2, 4'h1, "R9");
        sync_busy = 1'b0;
        chk(SEL_LOL, 4'h0, "R8");
        wr(2'd0, 4'h1);
        chk_reg(2'd0, 4'h0, "R8");

        // R6: reset with state loaded
        hold = 1'b1;
        tick();
        hold = 1'b0;
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk_reg(2'd0, 4'h0, "R6");
        chk_reg(2'd1, 4'h0, "R6");
        chk_reg(2'd2, 4'h0, "R6");
        chk(SEL_IRQN, 4'h1, "R6");

        tick();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule